// File: doc/BRIEF.md
# Reset Sequencer with Mode Sampling

This block produces the chip reset from an active-low external reset pin and a one-cycle watchdog reset request. The pin asserts reset at once, without a clock. Release is synchronised to the master clock through two flops. The processor is held in reset until a fixed number of clock edges after release, and a one-cycle fetch-start strobe then marks the first instruction fetch. A watchdog request starts the same timed sequence from inside the chip.

While the pin is low, the block samples two straps on each clock edge: a tri-state debug request, which is active low, and a boot-mode select. On pin release it latches both. The tri-state mode turns on a global output-enable kill. Watchdog resets keep the latched modes as they were. The block also gates the clock copy sent off chip, holds an I/O direction register that returns to all-input after any reset, and reports which kind of reset came last.

Top module: `rstseq_top`

## Requirements
- R1: A low level on `ext_rst_ni` drives `sys_rst_no`, `core_rst_no` and `fetch_start_o` low at once, without waiting for a clock edge.
- R2: After `ext_rst_ni` rises, `sys_rst_no` stays low through the first clock edge and goes high at the second clock edge.
- R3: `fetch_start_o` is high for exactly one cycle, starting at the 80th (FETCH_DLY) clock edge after `ext_rst_ni` rises. The first edge after the rise counts as 1. `core_rst_no` goes high at that same edge and stays high.
- R4: `strap_tri_ni` is sampled at every clock edge while the pin is low and at the first edge after release. Tri-state mode is latched as 1 only if the last 10 (TRI_WIN) samples were all low. One high sample in that window, or fewer than 10 samples in total, latches 0.
- R5: `boot_mode_o` takes the `strap_boot_i` value sampled at the first edge after the pin rises, and takes it at the second edge.
- R6: `oe_kill_o` is high exactly when tri-state mode is latched, which is shown on `tri_mode_o`.
- R7: A `wdt_req_i` pulse sampled at an edge while the pin is fully released counts as edge 1 of a new sequence. `sys_rst_no` and `core_rst_no` go low at that edge, and `sys_rst_no` returns high at edge 2. `fetch_start_o` pulses at edge 80. `tri_mode_o` and `boot_mode_o` keep their values.
- R8: A `wdt_req_i` pulse that arrives while the pin is low, or before `sys_rst_no` has been released by the pin, has no effect. After the pin releases, the cause is pin and the straps are latched as usual.
- R9: `clk_out_o` stays low while the pin is low and through the second edge after release. From the third edge on it follows the clock.
- R10: `io_dir_o` is all zero (all inputs) after any reset. A write through `io_dir_we_i` loads `io_dir_wd_i` at the next edge only while `sys_rst_no` is high. Writes made while it is low are ignored.
- R11: `rst_cause_o` is 0 after power-on reset, 1 from the second edge after a pin release, and 2 from the edge that accepts a watchdog request. A low `por_ni` clears the cause and both latched modes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low |
| wdt_req_i | input | 1 | Watchdog reset request, one-cycle synchronous pulse |
| strap_tri_ni | input | 1 | Tri-state debug strap, active low |
| strap_boot_i | input | 1 | Boot-mode strap |
| io_dir_we_i | input | 1 | Direction register write enable |
| io_dir_wd_i | input | NIO | Direction register write data (1 = output) |
| sys_rst_no | output | 1 | Chip-wide peripheral reset, active low |
| core_rst_no | output | 1 | Processor reset, active low |
| fetch_start_o | output | 1 | One-cycle first-fetch strobe |
| clk_out_o | output | 1 | Gated copy of the master clock |
| oe_kill_o | output | 1 | Global output-driver disable |
| tri_mode_o | output | 1 | Latched tri-state mode |
| boot_mode_o | output | 1 | Latched boot mode |
| rst_cause_o | output | 2 | Last reset cause: 0 power-on, 1 pin, 2 watchdog |
| io_dir_o | output | NIO | I/O direction bits (0 = input) |

## Verification
The bench builds the block with FETCH_DLY = 80 and TRI_WIN = 10, the values the requirements name, so both the release-to-fetch distance and the strap window are measured edge by edge at their real sizes. NIO is set to 16, which is enough to show a written pattern and its clearing. The strap table puts a single high sample just inside and just outside the 10-sample window. It also uses reset lengths one sample short of the window and exactly at the window.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        CAUSE_POR = 2'd0,
        CAUSE_PIN = 2'd1,
        CAUSE_WDT = 2'd2
    } rst_cause_e;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync (
    input  logic clk_i,
    input  logic arst_ni,
    output logic stg1_o,
    output logic stg2_o,
    output logic rel_pulse_o
);

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = 1'b1;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign stg1_o      = sync_q.s1;
    assign stg2_o      = sync_q.s2;
    assign rel_pulse_o = sync_q.s1 & ~sync_q.s2;

    AST_SYNC_ORDER: assert property (@(posedge clk_i) disable iff (!arst_ni)
        sync_q.s2 |-> sync_q.s1); // R2

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl #(
    parameter int FETCH_DLY = 80
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic stg1_i,
    input  logic wdt_acc_i,
    output logic hold_o,
    output logic fetch_o,
    output logic sysrel_o
);

    localparam int CNT_W = $clog2(FETCH_DLY);
    localparam int HIT   = FETCH_DLY - 2;

    typedef struct packed {
        logic             hold;
        logic             fetch;
        logic             sysrel;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.fetch = 1'b0;
        if (wdt_acc_i) begin
            ctl_d.hold   = 1'b1;
            ctl_d.sysrel = 1'b0;
            ctl_d.cnt    = '0;
        end else begin
            ctl_d.sysrel = stg1_i;
            if (ctl_q.hold && stg1_i) begin
                if (ctl_q.cnt == CNT_W'(HIT)) begin
                    ctl_d.hold  = 1'b0;
                    ctl_d.fetch = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            ctl_q.hold   <= 1'b1;
            ctl_q.fetch  <= 1'b0;
            ctl_q.sysrel <= 1'b0;
            ctl_q.cnt    <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign hold_o   = ctl_q.hold;
    assign fetch_o  = ctl_q.fetch;
    assign sysrel_o = ctl_q.sysrel;

    AST_FETCH_SINGLE: assert property (@(posedge clk_i) disable iff (!arst_ni)
        ctl_q.fetch |=> !ctl_q.fetch); // R3
    AST_CORE_REL_WITH_FETCH: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(ctl_q.hold) |-> ctl_q.fetch); // R3
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!arst_ni)
        ctl_q.cnt <= CNT_W'(HIT)); // R3
    AST_WDT_RESTARTS: assert property (@(posedge clk_i) disable iff (!arst_ni)
        wdt_acc_i |=> (ctl_q.hold && !ctl_q.sysrel)); // R7

endmodule

// File: rtl/rstseq_modes.sv
module rstseq_modes
    import rstseq_pkg::*;
#(
    parameter int TRI_WIN = 10
) (
    input  logic       clk_i,
    input  logic       por_ni,
    input  logic       smp_en_i,
    input  logic       latch_i,
    input  logic       wdt_acc_i,
    input  logic       strap_tri_ni,
    input  logic       strap_boot_i,
    output logic       tri_o,
    output logic       boot_o,
    output rst_cause_e cause_o
);

    localparam int RUN_W = $clog2(TRI_WIN + 1);

    typedef struct packed {
        logic [RUN_W-1:0] run;
        logic             boot_smp;
        logic             tri_m;
        logic             boot_m;
        rst_cause_e       cause;
    } mode_t;

    mode_t md_d, md_q;

    always_comb begin
        md_d = md_q;
        if (smp_en_i) begin
            if (strap_tri_ni) begin
                md_d.run = '0;
            end else if (md_q.run != RUN_W'(TRI_WIN)) begin
                md_d.run = md_q.run + 1'b1;
            end
            md_d.boot_smp = strap_boot_i;
        end
        if (latch_i) begin
            md_d.tri_m  = (md_q.run == RUN_W'(TRI_WIN));
            md_d.boot_m = md_q.boot_smp;
            md_d.cause  = CAUSE_PIN;
            md_d.run    = '0;
        end else if (wdt_acc_i) begin
            md_d.cause = CAUSE_WDT;
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            md_q.run      <= '0;
            md_q.boot_smp <= 1'b0;
            md_q.tri_m    <= 1'b0;
            md_q.boot_m   <= 1'b0;
            md_q.cause    <= CAUSE_POR;
        end else begin
            md_q <= md_d;
        end
    end

    assign tri_o   = md_q.tri_m;
    assign boot_o  = md_q.boot_m;
    assign cause_o = md_q.cause;

    AST_MODES_HOLD_ON_WDT: assert property (@(posedge clk_i) disable iff (!por_ni)
        wdt_acc_i |=> ($stable(md_q.tri_m) && $stable(md_q.boot_m))); // R7
    AST_TRI_NEEDS_FULL_RUN: assert property (@(posedge clk_i) disable iff (!por_ni)
        (latch_i && (md_q.run != RUN_W'(TRI_WIN))) |=> !md_q.tri_m); // R4
    AST_CAUSE_PIN_ON_LATCH: assert property (@(posedge clk_i) disable iff (!por_ni)
        latch_i |=> (md_q.cause == CAUSE_PIN)); // R11

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int FETCH_DLY = 80,
    parameter int TRI_WIN   = 10,
    parameter int NIO       = 32
) (
    input  logic           clk_i,
    input  logic           por_ni,
    input  logic           ext_rst_ni,
    input  logic           wdt_req_i,
    input  logic           strap_tri_ni,
    input  logic           strap_boot_i,
    input  logic           io_dir_we_i,
    input  logic [NIO-1:0] io_dir_wd_i,
    output logic           sys_rst_no,
    output logic           core_rst_no,
    output logic           fetch_start_o,
    output logic           clk_out_o,
    output logic           oe_kill_o,
    output logic           tri_mode_o,
    output logic           boot_mode_o,
    output logic [1:0]     rst_cause_o,
    output logic [NIO-1:0] io_dir_o
);

    typedef struct packed {
        logic [NIO-1:0] dir;
    } top_t;

    logic       pin_rst_n;
    logic       stg1, stg2, rel_pulse;
    logic       wdt_acc;
    logic       hold, fetch, sysrel;
    logic       tri_m, boot_m;
    rst_cause_e cause;
    logic       gate_q;
    top_t       top_d, top_q;

    assign pin_rst_n = ext_rst_ni & por_ni;
    assign wdt_acc   = wdt_req_i & stg2;

    rstseq_sync u_sync (
        .clk_i       (clk_i),
        .arst_ni     (pin_rst_n),
        .stg1_o      (stg1),
        .stg2_o      (stg2),
        .rel_pulse_o (rel_pulse)
    );

    rstseq_ctrl #(.FETCH_DLY(FETCH_DLY)) u_ctrl (
        .clk_i     (clk_i),
        .arst_ni   (pin_rst_n),
        .stg1_i    (stg1),
        .wdt_acc_i (wdt_acc),
        .hold_o    (hold),
        .fetch_o   (fetch),
        .sysrel_o  (sysrel)
    );

    rstseq_modes #(.TRI_WIN(TRI_WIN)) u_modes (
        .clk_i        (clk_i),
        .por_ni       (por_ni),
        .smp_en_i     (~stg1),
        .latch_i      (rel_pulse),
        .wdt_acc_i    (wdt_acc),
        .strap_tri_ni (strap_tri_ni),
        .strap_boot_i (strap_boot_i),
        .tri_o        (tri_m),
        .boot_o       (boot_m),
        .cause_o      (cause)
    );

    always_comb begin
        top_d = top_q;
        if (!sysrel) begin
            top_d.dir = '0;
        end else if (io_dir_we_i) begin
            top_d.dir = io_dir_wd_i;
        end
    end

    always_ff @(posedge clk_i or negedge pin_rst_n) begin
        if (!pin_rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_ff @(negedge clk_i or negedge pin_rst_n) begin
        if (!pin_rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= stg2;
        end
    end

    assign clk_out_o     = clk_i & gate_q;
    assign sys_rst_no    = sysrel;
    assign core_rst_no   = ~hold;
    assign fetch_start_o = fetch;
    assign oe_kill_o     = tri_m;
    assign tri_mode_o    = tri_m;
    assign boot_mode_o   = boot_m;
    assign rst_cause_o   = cause;
    assign io_dir_o      = top_q.dir;

    AST_GATE_OFF_IN_PIN_RST: assert property (@(posedge clk_i) disable iff (!por_ni)
        !ext_rst_ni |-> !gate_q); // R9
    AST_IODIR_CLEARED: assert property (@(posedge clk_i) disable iff (!pin_rst_n)
        !sysrel |=> (top_q.dir == '0)); // R10
    AST_WDT_IGNORED_EARLY: assert property (@(posedge clk_i) disable iff (!pin_rst_n)
        (wdt_req_i && !stg2 && !stg1) |=> !sysrel); // R8

endmodule

// File: tb/rstseq_top_tb.sv
`timescale 1ns/100ps
module rstseq_top_tb;

    localparam int NIO = 16;

    logic           clk = 1'b0;
    logic           por_n, ext_n, wdt, tri_n, boot, we;
    logic [NIO-1:0] wd;
    logic           sys_rst_n, core_rst_n, fetch, clk_out, oe_kill, tri_m, boot_m;
    logic [1:0]     cause;
    logic [NIO-1:0] dir;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    rstseq_top #(.FETCH_DLY(80), .TRI_WIN(10), .NIO(NIO)) u_dut (
        .clk_i (clk), .por_ni (por_n), .ext_rst_ni (ext_n), .wdt_req_i (wdt),
        .strap_tri_ni (tri_n), .strap_boot_i (boot), .io_dir_we_i (we),
        .io_dir_wd_i (wd), .sys_rst_no (sys_rst_n), .core_rst_no (core_rst_n),
        .fetch_start_o (fetch), .clk_out_o (clk_out), .oe_kill_o (oe_kill),
        .tri_mode_o (tri_m), .boot_mode_o (boot_m), .rst_cause_o (cause),
        .io_dir_o (dir)
    );

    // each entry: {reset length in edges, position of the single high tri sample (0 = none), boot, expected tri}
    localparam logic [23:0] VEC [0:6] = '{
        24'h0C_00_1_1, 24'h0C_01_0_0, 24'h0C_0A_1_0, 24'h0C_0B_0_1,
        24'h08_00_0_0, 24'h14_05_1_0, 24'h09_00_1_1
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // ends at the falling edge after release edge 1
    task automatic pin_reset(input int len, input int hipos, input logic b);
        @(negedge clk);
        ext_n = 1'b0;
        for (int i = 0; i < len; i++) begin
            tri_n = ((len + 1 - i) == hipos);
            boot  = ~b;
            @(posedge clk);
            @(negedge clk);
        end
        ext_n = 1'b1;
        tri_n = (hipos == 1);
        boot  = b;
        @(posedge clk);
        @(negedge clk);
        tri_n = 1'b1;
        boot  = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL TIMEOUT actual=running expected=finished");
        finish_run();
    end

    initial begin
        por_n = 0; ext_n = 0; wdt = 0; tri_n = 1; boot = 0; we = 0; wd = '0;
        repeat (3) @(negedge clk);
        check("R11 cause after por", cause, 0);
        check("R11 tri after por", tri_m, 0);
        check("R11 boot after por", boot_m, 0);
        check("R1 core reset at power-up", core_rst_n, 0);
        check("R1 sys reset at power-up", sys_rst_n, 0);
        por_n = 1;

        // strap table
        for (int v = 0; v < 7; v++) begin
            pin_reset(int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][4]);
            repeat (85) @(negedge clk);
            check($sformatf("R4 tri vec%0d", v), tri_m, VEC[v][0]);
            check($sformatf("R5 boot vec%0d", v), boot_m, VEC[v][4]);
            check($sformatf("R6 oe_kill vec%0d", v), oe_kill, VEC[v][0]);
        end

        // release timing, edge by edge
        pin_reset(12, 0, 1'b1);
        check("R2 sys reset after edge 1", sys_rst_n, 0);
        for (int k = 2; k <= 81; k++) begin
            @(posedge clk);
            #1;
            if (k == 2) check("R9 clk_out held at edge 2", clk_out, 0);
            if (k == 3) check("R9 clk_out running at edge 3", clk_out, 1);
            @(negedge clk);
            if (k == 2)  check("R2 sys reset released at edge 2", sys_rst_n, 1);
            if (k == 2)  check("R11 cause pin", cause, 1);
            if (k == 79) check("R3 no fetch at edge 79", {core_rst_n, fetch}, 2'b00);
            if (k == 80) check("R3 fetch at edge 80", {core_rst_n, fetch}, 2'b11);
            if (k == 81) check("R3 fetch ends at edge 81", {core_rst_n, fetch}, 2'b10);
        end

        // asynchronous assertion, watchdog and writes during pin reset
        #1 ext_n = 1'b0;
        #1;
        check("R1 async assert", {sys_rst_n, core_rst_n, fetch}, 3'b000);
        tri_n = 0; boot = 0; we = 1; wd = 16'hFFFF;
        for (int i = 0; i < 12; i++) begin
            wdt = (i == 5);
            @(posedge clk);
            #1;
            if (i == 3) check("R9 clk_out low in pin reset", clk_out, 0);
            @(negedge clk);
        end
        wdt = 0;
        check("R10 write ignored in reset", dir, 0);
        we = 0;
        ext_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tri_n = 1;
        repeat (85) @(negedge clk);
        check("R8 cause stays pin", cause, 1);
        check("R8 tri latched", tri_m, 1);
        check("R8 core released", core_rst_n, 1);

        // write then watchdog
        we = 1; wd = 16'hA5C3;
        @(negedge clk);
        we = 0;
        check("R10 write accepted", dir, 16'hA5C3);
        wdt = 1;
        @(negedge clk);
        wdt = 0;
        check("R7 wdt asserts resets", {sys_rst_n, core_rst_n}, 2'b00);
        check("R11 cause wdt", cause, 2);
        for (int k = 2; k <= 81; k++) begin
            @(negedge clk);
            if (k == 2)  check("R7 sys reset released at edge 2", sys_rst_n, 1);
            if (k == 2)  check("R10 dir cleared by wdt", dir, 0);
            if (k == 79) check("R7 no fetch at edge 79", fetch, 0);
            if (k == 80) check("R7 fetch at edge 80", {core_rst_n, fetch}, 2'b11);
            if (k == 81) check("R7 fetch ends", fetch, 0);
        end
        check("R7 tri kept", tri_m, 1);
        check("R7 boot kept", boot_m, 0);

        por_n = 0;
        #1;
        check("R11 por clears modes", {tri_m, boot_m, cause}, 4'b0000);
        finish_run();
    end

endmodule